// File: doc/BRIEF.md
# Triangular Dither PWM Sequencer

This block produces a pulse-width-modulated output whose duty cycle steps through a symmetric up-then-down triangle. An external RC network turns the pulse train into a slow triangular ramp, and a small scaled-down copy of that ramp is summed onto the input of an analog-to-digital converter. The block can then add resolution by averaging: each conversion in a burst sees a different dither offset, and the average shows where the input lies between two adjacent codes.

One carrier period of the PWM lasts exactly one conversion slot (PERIOD clocks, 56 by default). The compare value changes once per carrier period, so one full triangle spans OSR = 2^LOG2_OSR slots (16 by default, with LOG2_OSR from 2 to 4). A single-cycle burst-start pulse comes from the same period timer that starts the converter burst. It arms the sequencer, which then runs OSR carrier periods and goes quiet. A one-cycle step strobe marks the first clock of every carrier period, so converter sampling can be kept in line with the dither steps. The triangle levels are computed at elaboration from the parameters.

Top module: `tri_dither_pwm`

## Requirements
- R1: While rst_ni is low, and after reset until the first start pulse, pwm_o and step_o are both low.
- R2: During a burst, each carrier period is exactly PERIOD clocks long. step_o is high for one clock, on the first clock of each period, and low on every other clock.
- R3: A burst holds exactly OSR carrier periods, so step_o pulses OSR times. The first carrier period begins on the clock after the clock edge that samples start_i high.
- R4: The level for carrier period k (k = 0 .. OSR-1) is k*PERIOD/(OSR/2-1) for k < OSR/2, and (OSR-1-k)*PERIOD/(OSR/2-1) otherwise, using integer division. The two middle periods are at full duty (PERIOD) and the two end periods are at zero duty.
- R5: Within a carrier period, pwm_o is high on the first L clocks and low on the rest, where L is that period's level. The level never changes inside a period.
- R6: After the last carrier period of a burst, pwm_o and step_o stay low until the next start pulse.
- R7: A start pulse during a burst abandons it. A fresh burst then begins from period 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start pulse from the period timer |
| pwm_o | output | 1 | PWM output, goes to the external RC filter |
| step_o | output | 1 | One-clock strobe at each carrier period boundary during a burst |

## Verification
The assertions check on every clock that:
- the carrier counter stays in range and sits at zero when idle;
- the compare level holds steady between period boundaries and never exceeds full scale;
- a burst ends after its final period;
- a start pulse is followed by a strobe.

The exact triangle shape, the contiguity of the high time inside each period, the strobe count per burst and the quiet gaps between bursts appear only in the bench's full per-clock sweeps. The restart-mid-burst case also relies on the bench.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  // Triangle level for step k of an osr-step burst, peak equals period
  function automatic int tri_level(int k, int osr, int period);
    int half;
    int den;
    half = osr / 2;
    den  = (half > 1) ? half - 1 : 1;
    if (k < half) return (k * period) / den;
    return ((osr - 1 - k) * period) / den;
  endfunction
endpackage

// File: rtl/tdp_carrier.sv
module tdp_carrier #(
  parameter int PERIOD = 56,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (run_i)         cnt_q <= (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
    else                    cnt_q <= '0;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i && (cnt_q == CW'(PERIOD - 1));

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD)) else $error("carrier out of range"); // R2
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0) else $error("carrier moved while idle"); // R6
endmodule

// File: rtl/tdp_table.sv
module tdp_table
  import tdp_pkg::*;
#(
  parameter int PERIOD   = 56,
  parameter int LOG2_OSR = 4,
  localparam int OSR = 1 << LOG2_OSR,
  localparam int CW  = $clog2(PERIOD + 1)
) (
  input  logic [LOG2_OSR-1:0] idx_i,
  output logic [CW-1:0]       level_o
);
  logic [CW-1:0] lvl [OSR];

  for (genvar k = 0; k < OSR; k++) begin : g_lvl
    localparam int V = tri_level(k, OSR, PERIOD);
    assign lvl[k] = CW'(V);
  end

  assign level_o = lvl[idx_i];
endmodule

// File: rtl/tdp_seq.sv
module tdp_seq #(
  parameter int PERIOD   = 56,
  parameter int LOG2_OSR = 4,
  localparam int OSR = 1 << LOG2_OSR,
  localparam int CW  = $clog2(PERIOD + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wrap_i,
  input  logic [CW-1:0]       level_i,
  output logic [LOG2_OSR-1:0] look_o,
  output logic                busy_o,
  output logic [CW-1:0]       cmp_o
);
  logic                busy_q;
  logic [LOG2_OSR-1:0] idx_q;
  logic [CW-1:0]       cmp_q;
  logic                last;

  assign last   = (idx_q == LOG2_OSR'(OSR - 1));
  assign look_o = start_i ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cmp_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cmp_q  <= level_i;
    end else if (wrap_i) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
        cmp_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        cmp_q  <= level_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign cmp_o  = cmp_q;

  AST_CMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !wrap_i && !start_i) |=> $stable(cmp_q)) else $error("level moved mid-period"); // R5
  AST_CMP_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q <= CW'(PERIOD)) else $error("level above full scale"); // R4
  AST_BURST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wrap_i && last && !start_i) |=> !busy_q) else $error("burst overran"); // R3
endmodule

// File: rtl/tri_dither_pwm.sv
module tri_dither_pwm #(
  parameter int PERIOD   = 56,
  parameter int LOG2_OSR = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pwm_o,
  output logic step_o
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0]       cnt;
  logic                wrap;
  logic                busy;
  logic [CW-1:0]       cmp;
  logic [CW-1:0]       level;
  logic [LOG2_OSR-1:0] look;

  tdp_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk_i, .rst_ni, .clear_i(start_i), .run_i(busy), .cnt_o(cnt), .wrap_o(wrap)
  );

  tdp_table #(.PERIOD(PERIOD), .LOG2_OSR(LOG2_OSR)) u_table (
    .idx_i(look), .level_o(level)
  );

  tdp_seq #(.PERIOD(PERIOD), .LOG2_OSR(LOG2_OSR)) u_seq (
    .clk_i, .rst_ni, .start_i, .wrap_i(wrap), .level_i(level),
    .look_o(look), .busy_o(busy), .cmp_o(cmp)
  );

  assign pwm_o  = busy && (cnt < cmp);
  assign step_o = busy && (cnt == '0);

  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> step_o) else $error("start did not arm"); // R7
endmodule

// File: tb/tri_dither_pwm_tb_top.sv
module tri_dither_pwm_tb_top;
  localparam int PERIOD = 56;
  localparam int LOG2_OSR = 4;
  localparam int OSR = 1 << LOG2_OSR;
  localparam int HALF = OSR / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic pwm_o, step_o;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tri_dither_pwm #(.PERIOD(PERIOD), .LOG2_OSR(LOG2_OSR)) dut_i (
    .clk_i, .rst_ni, .start_i, .pwm_o, .step_o
  );

  function automatic int exp_level(int k);
    if (k < HALF) return (k * PERIOD) / (HALF - 1);
    return ((OSR - 1 - k) * PERIOD) / (HALF - 1);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Watch n clocks with no activity expected
  task automatic quiet(int n, string req);
    int act = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_o || step_o) act++;
      @(negedge clk_i);
    end
    check(act == 0, req, act, 0);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // Check nper periods of a burst just started (at negedge after the arming edge)
  task automatic watch_burst(int nper);
    for (int k = 0; k < nper; k++) begin
      int hi = 0, bad_shape = 0, bad_step = 0;
      int lv = exp_level(k);
      for (int j = 0; j < PERIOD; j++) begin
        if (step_o != (j == 0)) bad_step++;
        if (pwm_o) hi++;
        if (pwm_o != (j < lv)) bad_shape++;
        @(negedge clk_i);
      end
      check(bad_step == 0, "R2", bad_step, 0);
      check(hi == lv, "R4", hi, lv);
      check(bad_shape == 0, "R5", bad_shape, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!pwm_o && !step_o, "R1", {pwm_o, step_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    quiet(100, "R1");

    // Full burst, then idle
    pulse_start();
    watch_burst(OSR);
    quiet(3 * PERIOD, "R6");

    // Count strobes over a whole burst plus tail (R3)
    begin
      int n = 0;
      pulse_start();
      for (int i = 0; i < OSR * PERIOD + 2 * PERIOD; i++) begin
        if (step_o) n++;
        @(negedge clk_i);
      end
      check(n == OSR, "R3", n, OSR);
    end

    // Restart mid-burst (R7)
    pulse_start();
    watch_burst(3);
    repeat (17) @(negedge clk_i);
    pulse_start();
    check(step_o == 1'b1, "R7", step_o, 1);
    watch_burst(OSR);
    quiet(2 * PERIOD, "R6");

    // Back-to-back burst right after the end
    pulse_start();
    watch_burst(OSR);
    quiet(PERIOD, "R6");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule